// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block drives the clock and data lines of an I2C bus one primitive at a time. A controller above it hands over a single command: bus recovery, START, STOP, write a byte, or read a byte with a chosen acknowledge level. The engine replays the primitive as a fixed series of delay slots and pulses `done_o` when the last slot has elapsed. A write returns the acknowledge level the target drove. A read returns the received byte.

The length of one delay slot comes from a 16-bit reload value that is sampled when a command is accepted. SCL is driven push-pull. SDA is treated as open-drain: `sda_oe_o` pulls the line low, a logic 1 is sent by releasing the line, and the level on the wire comes back on `sda_i`. A byte-level sequencer issues the commands in order. Transactions, arbitration and clock stretching are handled by that sequencer or are not supported.

Top module: `i2cm_bit_engine`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_oe_o` is 0 (SDA released), `cmd_ready_o` is 1 and `done_o` is 0.
- R2: A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both 1. `cmd_ready_o` stays 0 from that edge until the command completes. A `cmd_valid_i` raised while busy is not taken and leaves no trace on the bus or on `done_o`. `done_o` is high for exactly one cycle per command.
- R3: One delay unit lasts `div_i` clock cycles, or 1 cycle when `div_i` is 0. The value is taken at acceptance. START and STOP take 4 units, WRITE 37, READ 29, RECOVER 40 and a reserved code 1. `done_o` rises in the cycle after the last unit ends.
- R4: START (op 1): after one idle unit, SDA is released. One unit later SCL goes high. One unit later SDA is pulled low. SCL stays high and SDA stays low for the final unit.
- R5: STOP (op 2): SCL goes low, then SDA is pulled low, then SCL rises, then SDA is released. The steps are one unit apart, and SCL stays high at the end.
- R6: WRITE (op 3) sends `cmd_data_i` MSB first. For each bit, SCL falls. One unit later SDA takes the bit value. SCL is then high for two units. SDA changes only while SCL is low.
- R7: After the eighth write bit, SDA is released and SCL is high for two units. The level of `sda_i` at the end of that high phase appears on `ack_o` (0 = ACK, 1 = NACK). SCL then falls for a final unit.
- R8: READ (op 4) releases SDA and gives eight clocks. Each clock is one unit low and two units high. `sda_i` is sampled one unit after each rising edge and shifted in MSB first. The byte appears on `rx_data_o`.
- R9: After the eighth read bit, SCL falls. One unit later SDA carries `cmd_ack_i` (0 pulls low, 1 releases). SCL is then high for two units and falls for a final unit.
- R10: RECOVER (op 0) releases SDA and gives nine SCL pulses, each two units low and two units high. A STOP as in R5 follows.
- R11: Op codes 5 to 7 are taken and complete after one unit with no change on `scl_o` or `sda_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Engine idle, command can be taken |
| cmd_op_i | input | 3 | 0 recover, 1 START, 2 STOP, 3 write, 4 read, 5-7 reserved |
| cmd_data_i | input | 8 | Byte to write |
| cmd_ack_i | input | 1 | Acknowledge level to send after a read |
| div_i | input | 16 | Delay unit length in clock cycles (0 means 1) |
| done_o | output | 1 | One-cycle pulse at command completion |
| ack_o | output | 1 | Acknowledge level sampled on the last write |
| rx_data_o | output | 8 | Byte received on the last read |
| scl_o | output | 1 | SCL drive level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Level on the SDA wire |

## Verification
Two of the block's functions can fall in the same cycle: the command handshake and a running primitive. That happens when a request arrives while a primitive is still clocking out. The bench raises `cmd_valid_i` with a different op for one cycle in the middle of a START. It then judges that the engine ignored the request: `cmd_ready_o` is low at that moment, the bus ends in the START end state, and no second `done_o` appears. A second pair that coincides is the completing tick and the acknowledge or data sample in the final sampled slot. The bench judges that pair by comparing `ack_o` and `rx_data_o` with the bits its target model drove. It repeats this across delay reloads of 0 to 3.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [2:0] OP_RECOVER = 3'd0;
  localparam logic [2:0] OP_START   = 3'd1;
  localparam logic [2:0] OP_STOP    = 3'd2;
  localparam logic [2:0] OP_WRITE   = 3'd3;
  localparam logic [2:0] OP_READ    = 3'd4;

  typedef struct packed {
    logic scl;
    logic sda;   // 1 = released
  } pins_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] unit_q, cnt_q;

  assign tick_o = run_i && (cnt_q == unit_q - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q <= DIV_W'(1);
      cnt_q  <= '0;
    end else if (start_i) begin
      unit_q <= (div_i == '0) ? DIV_W'(1) : div_i;
      cnt_q  <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + DIV_W'(1);
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < unit_q);
endmodule

// File: rtl/i2cm_step.sv
module i2cm_step
  import i2cm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RCV_PULSES = 9,
  parameter int IDX_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic [2:0]       op_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [1:0]       sub_o,
  output logic [IDX_W-1:0] nxt_idx_o,
  output logic [1:0]       nxt_sub_o,
  output logic             fin_o
);
  logic             busy_q;
  logic [2:0]       op_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       sub_q, sub_last;
  logic             last_step;

  always_comb begin
    sub_last = (op_q == OP_READ && idx_q < IDX_W'(DATA_W)) ? 2'd2 : 2'd3;
    case (op_q)
      OP_START, OP_STOP:  last_step = (sub_q == 2'd3);
      OP_WRITE, OP_READ:  last_step = (idx_q == IDX_W'(DATA_W + 1));
      OP_RECOVER:         last_step = (idx_q == IDX_W'(RCV_PULSES)) && (sub_q == 2'd3);
      default:            last_step = 1'b1;
    endcase
    if (start_i) begin
      nxt_idx_o = '0;
      nxt_sub_o = '0;
    end else if (sub_q == sub_last) begin
      nxt_idx_o = idx_q + IDX_W'(1);
      nxt_sub_o = '0;
    end else begin
      nxt_idx_o = idx_q;
      nxt_sub_o = sub_q + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_RECOVER;
      idx_q  <= '0;
      sub_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
      idx_q  <= '0;
      sub_q  <= '0;
    end else if (tick_i) begin
      if (last_step) busy_q <= 1'b0;
      else begin
        idx_q <= nxt_idx_o;
        sub_q <= nxt_sub_o;
      end
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign idx_o  = idx_q;
  assign sub_o  = sub_q;
  assign fin_o  = tick_i && last_step;

  // R2
  fin_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_o);
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 16,
  parameter int RCV_PULSES = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_ack_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              done_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              scl_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  localparam int IDX_MAX = (DATA_W > RCV_PULSES) ? DATA_W : RCV_PULSES;
  localparam int IDX_W   = $clog2(IDX_MAX + 2);

  logic              busy, tick, fin, accept;
  logic [2:0]        op;
  logic [IDX_W-1:0]  idx, nxt_idx;
  logic [1:0]        sub, nxt_sub;
  pins_t             pins_q;
  logic              done_q, ack_q;
  logic [DATA_W-1:0] rx_q, data_q;
  logic              ack_lvl_q;

  assign accept = cmd_valid_i && !busy;

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .start_i(accept), .run_i(busy), .div_i, .tick_o(tick)
  );

  i2cm_step #(.DATA_W(DATA_W), .RCV_PULSES(RCV_PULSES), .IDX_W(IDX_W)) u_step (
    .clk_i, .rst_ni, .start_i(accept), .op_i(cmd_op_i), .tick_i(tick),
    .busy_o(busy), .op_o(op), .idx_o(idx), .sub_o(sub),
    .nxt_idx_o(nxt_idx), .nxt_sub_o(nxt_sub), .fin_o(fin)
  );

  function automatic pins_t stop_pat(input logic [1:0] s, input pins_t cur);
    pins_t p = cur;
    case (s)
      2'd0: p.scl = 1'b0;
      2'd1: p.sda = 1'b0;
      2'd2: p.scl = 1'b1;
      default: p.sda = 1'b1;
    endcase
    return p;
  endfunction

  // Pin levels at entry to slot (i, s) of command o
  function automatic pins_t slot_pins(input logic [2:0] o, input logic [IDX_W-1:0] i,
                                      input logic [1:0] s, input logic [DATA_W-1:0] d,
                                      input logic a, input pins_t cur);
    pins_t p = cur;
    logic [DATA_W-1:0] sh;
    sh = d << i;
    case (o)
      OP_START: begin
        if (s == 2'd1) p.sda = 1'b1;
        if (s == 2'd2) p.scl = 1'b1;
        if (s == 2'd3) p.sda = 1'b0;
      end
      OP_STOP: p = stop_pat(s, cur);
      OP_WRITE, OP_READ: begin
        if (o == OP_READ && i < IDX_W'(DATA_W)) begin
          if (s == 2'd0) begin
            p.scl = 1'b0;
            if (i == '0) p.sda = 1'b1;
          end
          if (s == 2'd1) p.scl = 1'b1;
        end else if (i <= IDX_W'(DATA_W)) begin
          if (s == 2'd0) p.scl = 1'b0;
          if (s == 2'd1) p.sda = (o == OP_READ) ? a :
                                 (i < IDX_W'(DATA_W)) ? sh[DATA_W-1] : 1'b1;
          if (s == 2'd2) p.scl = 1'b1;
        end else begin
          p.scl = 1'b0;
        end
      end
      OP_RECOVER: begin
        if (i < IDX_W'(RCV_PULSES)) begin
          if (s == 2'd0) begin
            p.scl = 1'b0;
            if (i == '0) p.sda = 1'b1;
          end
          if (s == 2'd2) p.scl = 1'b1;
        end else begin
          p = stop_pat(s, cur);
        end
      end
      default: ;
    endcase
    return p;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q    <= '{scl: 1'b1, sda: 1'b1};
      done_q    <= 1'b0;
      ack_q     <= 1'b0;
      rx_q      <= '0;
      data_q    <= '0;
      ack_lvl_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (accept) begin
        data_q    <= cmd_data_i;
        ack_lvl_q <= cmd_ack_i;
        pins_q    <= slot_pins(cmd_op_i, '0, '0, cmd_data_i, cmd_ack_i, pins_q);
      end else if (tick && !fin) begin
        pins_q <= slot_pins(op, nxt_idx, nxt_sub, data_q, ack_lvl_q, pins_q);
      end
      if (tick && op == OP_WRITE && idx == IDX_W'(DATA_W) && sub == 2'd3)
        ack_q <= sda_i;
      if (tick && op == OP_READ && idx < IDX_W'(DATA_W) && sub == 2'd1)
        rx_q <= {rx_q[DATA_W-2:0], sda_i};
    end
  end

  assign cmd_ready_o = !busy;
  assign done_o      = done_q;
  assign ack_o       = ack_q;
  assign rx_data_o   = rx_q;
  assign scl_o       = pins_q.scl;
  assign sda_oe_o    = !pins_q.sda;

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);
  // R6
  wr_sda_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && op == OP_WRITE && !$stable(sda_oe_o)) |-> !scl_o);
  // R4
  start_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op == OP_START) |-> (scl_o && sda_oe_o));
  // R5
  stop_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op == OP_STOP || op == OP_RECOVER)) |-> (scl_o && !sda_oe_o));
  // R8
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && op == OP_READ && idx < IDX_W'(DATA_W)) |-> !sda_oe_o);
  // R10
  rcv_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && op == OP_RECOVER && idx < IDX_W'(RCV_PULSES)) |-> !sda_oe_o);
endmodule

// File: tb/sim_i2cm_bit_engine.sv
`timescale 1ns/1ps
module sim_i2cm_bit_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'h00;
  logic cmd_ack = 1'b0;
  logic [15:0] div = 16'd1;
  logic done, ack, scl, sda_oe;
  logic [7:0] rx;
  logic slave_low = 1'b0;
  logic sda_line;

  int n_tests = 0, n_fail = 0;
  logic e_scl = 1'b1, e_sda = 1'b1;

  assign sda_line = !(sda_oe || slave_low);

  always #2.5 clk = ~clk;

  i2cm_bit_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_data_i(cmd_data), .cmd_ack_i(cmd_ack), .div_i(div),
    .done_o(done), .ack_o(ack), .rx_data_o(rx), .scl_o(scl), .sda_oe_o(sda_oe),
    .sda_i(sda_line)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Expected pin model per slot k, from the requirements
  task automatic model_slot(input int op, input int k, input logic [7:0] d, input logic a);
    int b, s;
    case (op)
      1: begin
        if (k == 1) e_sda = 1; if (k == 2) e_scl = 1; if (k == 3) e_sda = 0;
      end
      2: begin
        if (k == 0) e_scl = 0; if (k == 1) e_sda = 0; if (k == 2) e_scl = 1; if (k == 3) e_sda = 1;
      end
      3: begin
        b = k / 4; s = k % 4;
        if (k == 36) e_scl = 0;
        else begin
          if (s == 0) e_scl = 0;
          if (s == 1) e_sda = (b < 8) ? d[7-b] : 1'b1;
          if (s == 2) e_scl = 1;
        end
      end
      4: begin
        if (k < 24) begin
          s = k % 3;
          if (s == 0) e_scl = 0;
          if (k == 0) e_sda = 1;
          if (s == 1) e_scl = 1;
        end else begin
          if (k == 24 || k == 28) e_scl = 0;
          if (k == 25) e_sda = a;
          if (k == 26) e_scl = 1;
        end
      end
      0: begin
        if (k < 36) begin
          s = k % 4;
          if (s == 0) e_scl = 0;
          if (k == 0) e_sda = 1;
          if (s == 2) e_scl = 1;
        end else begin
          s = k - 36;
          if (s == 0) e_scl = 0; if (s == 1) e_sda = 0; if (s == 2) e_scl = 1; if (s == 3) e_sda = 1;
        end
      end
      default: ;
    endcase
  endtask

  task automatic run(input int op, input logic [7:0] d, input logic a, input int dv,
                     input logic [7:0] sbits, input logic sack, input string req);
    int unit, nsteps;
    unit = (dv == 0) ? 1 : dv;
    case (op)
      0: nsteps = 40; 1: nsteps = 4; 2: nsteps = 4; 3: nsteps = 37; 4: nsteps = 29;
      default: nsteps = 1;
    endcase
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_data = d; cmd_ack = a; div = 16'(dv);
    @(posedge clk); #1 cmd_valid = 0;
    for (int k = 0; k < nsteps; k++) begin
      model_slot(op, k, d, a);
      for (int c = 0; c < unit; c++) begin
        @(negedge clk);
        if (c == 0) begin
          if (op == 4 && k < 24) slave_low = !sbits[7 - k/3];
          else if (op == 3 && k >= 32 && k < 36) slave_low = !sack;
          else slave_low = 0;
        end
      end
      chk(scl == e_scl, {req, " scl"}, scl, e_scl);
      chk(sda_oe == !e_sda, {req, " sda_oe"}, sda_oe, !e_sda);
      chk(done == 0, "R3 no early done", done, 0);
    end
    @(negedge clk);
    slave_low = 0;
    chk(done == 1, "R3 done timing", done, 1);
    chk(cmd_ready == 1, "R2 ready after done", cmd_ready, 1);
    if (op == 3) chk(ack == sack, "R7 ack sample", ack, sack);
    if (op == 4) chk(rx == sbits, "R8 read byte", rx, sbits);
    @(negedge clk);
    chk(done == 0, "R2 done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(scl == 1, "R1 reset scl", scl, 1);
    chk(sda_oe == 0, "R1 reset sda", sda_oe, 0);
    chk(cmd_ready == 1, "R1 reset ready", cmd_ready, 1);
    chk(done == 0, "R1 reset done", done, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run(0, 8'h00, 0, 1, 8'h00, 0, "R10 recover");
    run(1, 8'h00, 0, 1, 8'h00, 0, "R4 start");
    for (int i = 0; i < 8; i++)
      run(3, 8'(i * 53 + 27), 0, i % 4, 8'h00, i[0], "R6 write");
    for (int i = 0; i < 8; i++)
      run(4, 8'h00, i[0], (i + 1) % 4, 8'(i * 29 + 150), 0, "R9 read");
    run(2, 8'h00, 0, 2, 8'h00, 0, "R5 stop");
    run(6, 8'h00, 0, 2, 8'h00, 0, "R11 reserved");
    run(0, 8'h00, 0, 0, 8'h00, 0, "R10 recover div0");

    // R2: request during a running START is ignored
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd1; div = 16'd3;
    @(posedge clk); #1 cmd_valid = 0;
    repeat (2) @(negedge clk);
    chk(cmd_ready == 0, "R2 busy not ready", cmd_ready, 0);
    cmd_valid = 1; cmd_op = 3'd4;
    @(negedge clk);
    cmd_valid = 0;
    for (int w = 0; w < 100 && !done; w++) @(negedge clk);
    chk(done == 1, "R2 first done", done, 1);
    for (int w = 0; w < 20; w++) begin
      @(negedge clk);
      chk(done == 0 && scl == 1 && sda_oe == 1, "R2 ignored request", {done, scl, sda_oe}, 3'b011);
    end
    e_scl = 1; e_sda = 0;
    run(2, 8'h00, 0, 1, 8'h00, 0, "R5 stop end");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule